// File: doc/BRIEF.md
# Masked Data-Address Watchpoint Bank

This block holds a small bank of data watchpoints that observe the address and direction of every load/store access. Each watchpoint keeps a 32-bit watch address and a control word. The control word carries one enable for loads, one for stores, and a low-order mask field. The mask field picks a naturally aligned power-of-two region around the watch address. When a valid access falls inside an armed region and its direction is enabled, the block raises a break request in the same cycle as the access. The request therefore arrives before the access can take effect.

Software may write a mask field whose ones do not form a single run from the top. The block detects this and raises a one-cycle error pulse. It then stores a repaired field that keeps only the leading run of ones.

Each watchpoint runs a two-state machine, SLOT_OFF and SLOT_WATCH. After reset it sits in SLOT_OFF. The transition ARM (a control write with either enable set) moves it to SLOT_WATCH. The transition DISARM (a control write with both enables clear) moves it back to SLOT_OFF. Any other control write, and any address write, leaves the state unchanged.

Top module: `dwatch_bank`

## Requirements
- R1: After reset every control word is clear, so no access raises `brk_req` and `mask_err` is low.
- R2: The control word has the mask field in bits [MASK_W-1:0], the load enable in bit MASK_W and the store enable in bit MASK_W+1. A store (`acc_is_store`=1) can match only with the store enable set, and a load (`acc_is_store`=0) only with the load enable set.
- R3: The effective mask is all ones above bit MASK_W-1, with the stored mask field below. An access matches when `(acc_addr & mask) == (watch & mask)`.
- R4: Take `inv` as the inverted MASK_W-bit field. A control write whose field gives a nonzero `(inv+1) & inv` makes `mask_err` high for exactly the cycle that follows the write. Any other control write leaves it low.
- R5: The stored field keeps the leading run of ones counted from bit MASK_W-1, and every bit from the first zero downward is cleared.
- R6: `brk_req` is combinational. It is high in the same cycle as a matching access and is never high while `acc_valid` is low.
- R7: When several watchpoints match, `brk_idx` gives the lowest-numbered one.
- R8: A write to the address or control register applies from the next cycle on. A control write with both enables clear disarms the watchpoint (DISARM to SLOT_OFF).
- R9: A control write with an enable set arms the watchpoint (ARM to SLOT_WATCH). In SLOT_OFF both enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Watchpoint selected for the write |
| cfg_is_ctrl | input | 1 | 1 writes the control word, 0 writes the watch address |
| cfg_wdata | input | AW | Write data |
| acc_valid | input | 1 | Access strobe from the load/store unit |
| acc_addr | input | AW | Access address |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| brk_req | output | 1 | Break request, valid in the access cycle |
| brk_idx | output | IDX_W | Lowest matching watchpoint |
| mask_err | output | 1 | Pulse after a non-contiguous mask write |

## Verification
Every one of the 64 mask-field values is written to one watchpoint. For each value the bench sweeps 128 addresses whose low seven bits vary. Contiguous and broken masks are told apart through both `mask_err` and the match region. Bit 6 of the sweep lies above the field, which exposes a wrong upper mask. Separate patterns use the load-only, store-only and disarmed settings, an overlap of two watchpoints for priority, and a move of the watch address.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    typedef enum logic [0:0] {
        SLOT_OFF   = 1'b0,
        SLOT_WATCH = 1'b1
    } slot_state_e;
endpackage

// File: rtl/dwb_mask_fix.sv
// Repairs a mask field to its leading run of ones and flags broken fields.
module dwb_mask_fix #(
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] raw,
    output logic [MASK_W-1:0] fixed,
    output logic              bad
);
    logic [MASK_W-1:0] inv;
    logic [MASK_W-1:0] probe;
    int                lead;
    logic              run;

    always_comb begin
        lead = 0;
        run  = 1'b1;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (run && raw[i]) lead = lead + 1;
            else               run  = 1'b0;
        end
        for (int i = 0; i < MASK_W; i++) begin
            fixed[i] = (i >= MASK_W - lead);
        end
    end

    assign inv   = ~raw;
    assign probe = (inv + 1'b1) & inv;
    assign bad   = |probe;
endmodule

// File: rtl/dwb_slot.sv
// One watchpoint: registers, arm/disarm state machine, comparator.
module dwb_slot
    import dwb_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MASK_W = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_ctrl,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_store,
    output logic          hit,
    output logic          bad_mask
);
    localparam int LD_BIT = MASK_W;
    localparam int ST_BIT = MASK_W + 1;

    slot_state_e       state, state_nxt;
    logic [AW-1:0]     watch_q;
    logic [MASK_W-1:0] field_q;
    logic              ld_en_q, st_en_q;
    logic [MASK_W-1:0] fixed_w;
    logic              bad_w;
    logic              any_en_w;
    logic [AW-1:0]     full_mask;
    logic              dir_ok, addr_ok;

    dwb_mask_fix #(.MASK_W(MASK_W)) u_fix (
        .raw   (wdata[MASK_W-1:0]),
        .fixed (fixed_w),
        .bad   (bad_w)
    );

    assign any_en_w = wdata[LD_BIT] | wdata[ST_BIT];
    assign bad_mask = wr_ctrl & bad_w;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SLOT_OFF:   if (wr_ctrl && any_en_w)  state_nxt = SLOT_WATCH; // ARM
            SLOT_WATCH: if (wr_ctrl && !any_en_w) state_nxt = SLOT_OFF;   // DISARM
            default:    state_nxt = SLOT_OFF;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch_q <= '0;
            field_q <= '0;
            ld_en_q <= 1'b0;
            st_en_q <= 1'b0;
        end else begin
            if (wr_addr) watch_q <= wdata;
            if (wr_ctrl) begin
                field_q <= fixed_w;
                ld_en_q <= wdata[LD_BIT];
                st_en_q <= wdata[ST_BIT];
            end
        end
    end

    // outputs
    assign full_mask = {{(AW-MASK_W){1'b1}}, field_q};

    always_comb begin
        dir_ok  = acc_store ? st_en_q : ld_en_q;
        addr_ok = ((acc_addr ^ watch_q) & full_mask) == '0;
        hit     = dir_ok && addr_ok;
    end

    // R9
    off_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_OFF) |-> !(ld_en_q || st_en_q));

    // R5
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~field_q) + 1'b1) & (~field_q)) == '0);
endmodule

// File: rtl/dwb_prio.sv
// Lowest-index-first pick among matching watchpoints.
module dwb_prio #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     gnt
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any    = 1'b1;
                idx    = IDX_W'(i);
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dwatch_bank.sv
module dwatch_bank #(
    parameter int NUM_WP = 2,
    parameter int AW     = 32,
    parameter int MASK_W = 6,
    localparam int IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic             cfg_is_ctrl,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic             acc_is_store,
    output logic             brk_req,
    output logic [IDX_W-1:0] brk_idx,
    output logic             mask_err
);
    logic [NUM_WP-1:0] hit_w, bad_w, hit_v, gnt_w;
    logic              err_q;

    for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
        logic sel;
        assign sel = cfg_we && (cfg_sel == IDX_W'(g));
        dwb_slot #(.AW(AW), .MASK_W(MASK_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (sel && !cfg_is_ctrl),
            .wr_ctrl   (sel && cfg_is_ctrl),
            .wdata     (cfg_wdata),
            .acc_addr  (acc_addr),
            .acc_store (acc_is_store),
            .hit       (hit_w[g]),
            .bad_mask  (bad_w[g])
        );
    end

    assign hit_v = acc_valid ? hit_w : '0;

    dwb_prio #(.N(NUM_WP), .IDX_W(IDX_W)) u_prio (
        .req (hit_v),
        .any (brk_req),
        .idx (brk_idx),
        .gnt (gnt_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |bad_w;
    end
    assign mask_err = err_q;

    // R6
    brk_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> acc_valid);

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_w) && (brk_req == (gnt_w != '0)));

    // R7
    idx_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> hit_w[brk_idx]);

    // R4
    err_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |-> $past(cfg_we && cfg_is_ctrl));
endmodule

// File: tb/tb_dwatch_bank.sv
module tb_dwatch_bank;
    localparam int NUM_WP = 2;
    localparam int AW     = 32;
    localparam int MASK_W = 6;
    localparam int IDX_W  = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_sel = '0;
    logic             cfg_is_ctrl = 1'b0;
    logic [AW-1:0]    cfg_wdata = '0;
    logic             acc_valid = 1'b0;
    logic [AW-1:0]    acc_addr = '0;
    logic             acc_is_store = 1'b0;
    logic             brk_req;
    logic [IDX_W-1:0] brk_idx;
    logic             mask_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dwatch_bank #(.NUM_WP(NUM_WP), .AW(AW), .MASK_W(MASK_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_is_ctrl(cfg_is_ctrl), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_store(acc_is_store),
        .brk_req(brk_req), .brk_idx(brk_idx), .mask_err(mask_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input bit is_ctrl, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = IDX_W'(sel); cfg_is_ctrl = is_ctrl; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic acc(input bit v, input logic [AW-1:0] a, input bit st);
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_is_store = st;
        #1;
    endtask

    function automatic logic [AW-1:0] ctrl_word(input bit st, input bit ld, input int fld);
        return AW'((int'(st) << (MASK_W+1)) | (int'(ld) << MASK_W) | (fld & 63));
    endfunction

    function automatic int fix_field(input int f);
        int lead = 0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (((f >> i) & 1) == 1) lead++;
            else break;
        end
        return (~((1 << (MASK_W - lead)) - 1)) & 63;
    endfunction

    function automatic bit bad_field(input int f);
        int inv = (~f) & 63;
        return (((inv + 1) & inv) & 63) != 0;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] wa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(mask_err == 1'b0, "R1", mask_err, 0);
        acc(1'b1, 32'h0, 1'b1);
        check(brk_req == 1'b0, "R1", brk_req, 0);
        acc(1'b1, 32'h0, 1'b0);
        check(brk_req == 1'b0, "R1", brk_req, 0);

        // R3 R4 R5 exhaustive field sweep on watchpoint 0
        wa = 32'h1234_5678;
        wr(0, 1'b0, wa);
        for (int f = 0; f < 64; f++) begin
            int fx;
            logic [AW-1:0] m;
            wr(0, 1'b1, ctrl_word(1'b1, 1'b1, f));
            check(mask_err == bad_field(f), "R4", mask_err, bad_field(f));
            fx = fix_field(f);
            m  = {{(AW-MASK_W){1'b1}}, MASK_W'(fx)};
            for (int off = 0; off < 128; off++) begin
                logic [AW-1:0] a;
                bit exp;
                a   = (wa & ~32'h7F) | AW'(off);
                exp = ((a ^ wa) & m) == '0;
                acc(1'b1, a, off[0]);
                check(brk_req == exp, "R5_R3", brk_req, exp);
                if (exp) check(brk_idx == 0, "R7", brk_idx, 0);
            end
        end
        acc(1'b0, 32'h0, 1'b0);
        check(mask_err == 1'b0, "R4", mask_err, 0);

        // R3 far address misses
        acc(1'b1, wa ^ 32'h0010_0000, 1'b0);
        check(brk_req == 1'b0, "R3", brk_req, 0);

        // R2 direction: 8-byte region, loads only
        wr(0, 1'b1, ctrl_word(1'b0, 1'b1, 6'b111000));
        acc(1'b1, wa, 1'b0);
        check(brk_req == 1'b1, "R2", brk_req, 1);
        acc(1'b1, wa, 1'b1);
        check(brk_req == 1'b0, "R2", brk_req, 0);
        wr(0, 1'b1, ctrl_word(1'b1, 1'b0, 6'b111000));
        acc(1'b1, wa, 1'b1);
        check(brk_req == 1'b1, "R2", brk_req, 1);
        acc(1'b1, wa, 1'b0);
        check(brk_req == 1'b0, "R2", brk_req, 0);

        // R6 no request without valid
        acc(1'b0, wa, 1'b1);
        check(brk_req == 1'b0, "R6", brk_req, 0);

        // R7 priority with overlapping regions
        wr(0, 1'b1, ctrl_word(1'b1, 1'b1, 6'b110000));
        wr(1, 1'b0, wa);
        wr(1, 1'b1, ctrl_word(1'b1, 1'b1, 6'b110000));
        acc(1'b1, wa, 1'b0);
        check(brk_req == 1'b1 && brk_idx == 0, "R7", brk_idx, 0);

        // R8 disarm wp0, wp1 takes over
        wr(0, 1'b1, ctrl_word(1'b0, 1'b0, 6'b111111));
        acc(1'b1, wa, 1'b0);
        check(brk_req == 1'b1 && brk_idx == 1, "R8", brk_idx, 1);

        // R9 re-arm wp0 at a moved address (R8 reprogramming)
        wr(0, 1'b0, 32'hABCD_0000);
        wr(0, 1'b1, ctrl_word(1'b1, 1'b0, 6'b111111));
        acc(1'b1, 32'hABCD_0000, 1'b1);
        check(brk_req == 1'b1 && brk_idx == 0, "R9", brk_idx, 0);
        wr(1, 1'b1, ctrl_word(1'b0, 1'b0, 0));
        acc(1'b1, wa, 1'b1);
        check(brk_req == 1'b0, "R8", brk_req, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule